// File: doc/BRIEF.md
# Debug Trigger State Sequencer

This block is the state sequencer of an on-chip debug trigger. It steps through three working states (State1, State2, State3) and a terminal Final state. Three single-cycle comparator match pulses drive it. Each working state owns a 4-bit selection code, and that code says which match channels cause a move and where each one goes. Software programs the three codes through a small register window, which a 2-bit page selector steers. It then raises the arm input. When the sequencer reaches Final, it emits a one-cycle pulse that downstream logic uses as the debug trigger, and it disarms itself.

A match that the active code does not list is ignored. When several matches arrive together, a match that leads to Final beats every other match. Among the remaining listed matches, the lowest channel number wins. The codes can only be changed while the sequencer is disarmed.

Top module: `seq_trigger_sequencer`

## Requirements
- R1: After reset the sequencer is disarmed, shows State1, drives final_o low, all three codes are zero and rd_data reads zero.
- R2: The state output encodes Final=00, State1=01, State2=10, State3=11. A rising edge on arm while disarmed sets armed_o and State1 one clock later. While arm is low the sequencer stays disarmed in State1.
- R3: In State1, code 1101 sends match[0] or match[2] to Final and match[1] to State2. Every other State1 code, including the reserved ones, causes no transition.
- R4: In State2, the codes map matches as follows. Code 0000 sends match[0] to State1 and match[2] to State3. Code 0001 sends match[1] to State3. Code 0010 sends match[2] to State3. Code 0011 sends match[0] to Final and match[1] to State3. Code 0100 sends match[1] to State1 and match[2] to State3. Codes 0101 to 1111 cause no transition.
- R5: When several matches are active in one cycle, a listed match leading to Final wins. Otherwise the lowest-numbered listed match wins. For example, State1 code 1101 with match[0] and match[1] together goes to Final.
- R6: Matches that the active code does not list, and any match while disarmed, leave the state unchanged.
- R7: Entering Final raises final_o for exactly one cycle and clears armed_o. The state then shows Final until arm is dropped.
- R8: page_sel 00, 01 and 10 open the State1, State2 and State3 code registers; 11 opens none. A write stores wr_data[3:0]. rd_data shows the open register one cycle after page_sel is set, with bits 7:4 always zero and all zeros for page 11.
- R9: Register writes are ignored while armed_o is high.
- R10: In State3 the same code table as State1 applies (code 1101: match[0]/match[2] to Final, match[1] to State2; every other code causes no transition).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| page_sel | input | 2 | Register window page selector |
| wr_en | input | 1 | Write strobe for the open register |
| wr_data | input | 8 | Write data; bits 3:0 are stored |
| rd_data | output | 8 | Registered readback of the open register |
| arm | input | 1 | Arm level; a rising edge arms, low disarms |
| match | input | 3 | Single-cycle comparator match pulses, channel 0 to 2 |
| state_o | output | 2 | Current sequencer state |
| armed_o | output | 1 | Sequencer armed |
| final_o | output | 1 | One-cycle pulse on entering Final |

## Verification
Every result is registered exactly once. A match pulse driven before a clock edge shows in state_o, armed_o and final_o right after that edge. Arming shows one edge after arm rises. Readback appears one edge after page_sel is set. The bench drives inputs on the falling clock edge and samples one falling edge later, so each check looks at the cycle right after the edge that should produce it. The sweep covers every code in every working state with every non-empty match combination.

// File: rtl/seq_pkg.sv
package seq_pkg;
  typedef enum logic [1:0] {
    ST_FINAL = 2'd0,
    ST_ONE   = 2'd1,
    ST_TWO   = 2'd2,
    ST_THREE = 2'd3
  } seq_state_t;

  typedef struct packed {
    logic       hit;
    seq_state_t dest;
  } route_t;
endpackage

// File: rtl/seq_code_bank.sv
module seq_code_bank #(
  parameter int NUM_REGS = 3,
  parameter int CODE_W   = 4,
  parameter int DATA_W   = 8,
  parameter int PAGE_W   = 2
) (
  input  logic                             clk,
  input  logic                             rst,
  input  logic                             wr_en,
  input  logic                             wr_lock,
  input  logic [PAGE_W-1:0]                page,
  input  logic [DATA_W-1:0]                wr_data,
  output logic [NUM_REGS-1:0][CODE_W-1:0]  codes,
  output logic [DATA_W-1:0]                rd_data
);
  localparam int PAD_W = DATA_W - CODE_W;

  logic [CODE_W-1:0] rd_sel;

  genvar gi;
  generate
    for (gi = 0; gi < NUM_REGS; gi++) begin : g_reg
      always_ff @(posedge clk) begin
        if (rst)
          codes[gi] <= '0;
        else if (wr_en && !wr_lock && (page == PAGE_W'(gi)))
          codes[gi] <= wr_data[CODE_W-1:0];
      end
    end
  endgenerate

  always_comb begin
    rd_sel = '0;
    for (int i = 0; i < NUM_REGS; i++)
      if (page == PAGE_W'(i)) rd_sel = codes[i];
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else     rd_data <= {{PAD_W{1'b0}}, rd_sel};
  end

  p_locked_write_r9: assert property (@(posedge clk) disable iff (rst)
    wr_lock |=> $stable(codes));
  p_upper_zero_r8: assert property (@(posedge clk) disable iff (rst)
    rd_data[DATA_W-1:CODE_W] == '0);
endmodule

// File: rtl/seq_route_decode.sv
module seq_route_decode
  import seq_pkg::*;
#(
  parameter int CODE_W = 4,
  parameter int NUM_CH = 3
) (
  input  seq_state_t                 cur_state,
  input  logic [CODE_W-1:0]          code,
  output route_t [NUM_CH-1:0]        routes
);
  function automatic route_t mk(input seq_state_t d);
    route_t r;
    r.hit  = 1'b1;
    r.dest = d;
    return r;
  endfunction

  // State1 and State3 share this table (R3, R10)
  function automatic route_t outer_table(input logic [CODE_W-1:0] c, input int ch);
    route_t r;
    r = '0;
    if (c == CODE_W'(4'b1101)) begin
      if (ch == 1) r = mk(ST_TWO);
      else         r = mk(ST_FINAL);
    end
    return r;
  endfunction

  // State2 table (R4)
  function automatic route_t middle_table(input logic [CODE_W-1:0] c, input int ch);
    route_t r;
    r = '0;
    case (c)
      CODE_W'(4'b0000): if (ch == 0) r = mk(ST_ONE);
                        else if (ch == 2) r = mk(ST_THREE);
      CODE_W'(4'b0001): if (ch == 1) r = mk(ST_THREE);
      CODE_W'(4'b0010): if (ch == 2) r = mk(ST_THREE);
      CODE_W'(4'b0011): if (ch == 0) r = mk(ST_FINAL);
                        else if (ch == 1) r = mk(ST_THREE);
      CODE_W'(4'b0100): if (ch == 1) r = mk(ST_ONE);
                        else if (ch == 2) r = mk(ST_THREE);
      default: r = '0;
    endcase
    return r;
  endfunction

  genvar gc;
  generate
    for (gc = 0; gc < NUM_CH; gc++) begin : g_ch
      always_comb begin
        case (cur_state)
          ST_ONE, ST_THREE: routes[gc] = outer_table(code, gc);
          ST_TWO:           routes[gc] = middle_table(code, gc);
          default:          routes[gc] = '0;
        endcase
      end
    end
  endgenerate
endmodule

// File: rtl/seq_priority.sv
module seq_priority
  import seq_pkg::*;
#(
  parameter int NUM_CH = 3
) (
  input  logic [NUM_CH-1:0]   match,
  input  route_t [NUM_CH-1:0] routes,
  output logic                take,
  output seq_state_t          dest
);
  logic       any_final;
  logic       any_hit;
  seq_state_t low_dest;

  always_comb begin
    any_final = 1'b0;
    any_hit   = 1'b0;
    low_dest  = ST_ONE;
    for (int i = NUM_CH - 1; i >= 0; i--) begin
      if (match[i] && routes[i].hit) begin
        any_hit  = 1'b1;
        low_dest = routes[i].dest;
        if (routes[i].dest == ST_FINAL) any_final = 1'b1;
      end
    end
    take = any_hit;
    dest = any_final ? ST_FINAL : low_dest;
  end
endmodule

// File: rtl/seq_trigger_sequencer.sv
module seq_trigger_sequencer
  import seq_pkg::*;
#(
  parameter int NUM_CH  = 3,
  parameter int CODE_W  = 4,
  parameter int DATA_W  = 8,
  parameter int PAGE_W  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [PAGE_W-1:0] page_sel,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  input  logic              arm,
  input  logic [NUM_CH-1:0] match,
  output logic [1:0]        state_o,
  output logic              armed_o,
  output logic              final_o
);
  localparam int NUM_REGS = 3;

  seq_state_t                       state_q;
  logic                             armed_q;
  logic                             final_q;
  logic                             arm_q;
  logic [NUM_REGS-1:0][CODE_W-1:0]  codes;
  logic [CODE_W-1:0]                act_code;
  route_t [NUM_CH-1:0]              routes;
  logic                             take;
  seq_state_t                       dest;

  seq_code_bank #(
    .NUM_REGS(NUM_REGS), .CODE_W(CODE_W), .DATA_W(DATA_W), .PAGE_W(PAGE_W)
  ) u_bank (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_lock(armed_q),
    .page(page_sel), .wr_data(wr_data), .codes(codes), .rd_data(rd_data)
  );

  always_comb begin
    case (state_q)
      ST_ONE:   act_code = codes[0];
      ST_TWO:   act_code = codes[1];
      ST_THREE: act_code = codes[2];
      default:  act_code = '0;
    endcase
  end

  seq_route_decode #(.CODE_W(CODE_W), .NUM_CH(NUM_CH)) u_dec (
    .cur_state(state_q), .code(act_code), .routes(routes)
  );

  seq_priority #(.NUM_CH(NUM_CH)) u_pri (
    .match(match), .routes(routes), .take(take), .dest(dest)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_ONE;
      armed_q <= 1'b0;
      final_q <= 1'b0;
      arm_q   <= 1'b0;
    end else begin
      arm_q   <= arm;
      final_q <= 1'b0;
      if (!arm) begin
        armed_q <= 1'b0;
        state_q <= ST_ONE;
      end else if (!armed_q) begin
        if (!arm_q) begin
          armed_q <= 1'b1;
          state_q <= ST_ONE;
        end
      end else if (take) begin
        state_q <= dest;
        if (dest == ST_FINAL) begin
          armed_q <= 1'b0;
          final_q <= 1'b1;
        end
      end
    end
  end

  assign state_o = state_q;
  assign armed_o = armed_q;
  assign final_o = final_q;

  p_final_disarms_r7: assert property (@(posedge clk) disable iff (rst)
    final_o |-> (!armed_o && state_o == 2'b00));
  p_final_single_r7: assert property (@(posedge clk) disable iff (rst)
    final_o |=> !final_o);
  p_arm_low_r2: assert property (@(posedge clk) disable iff (rst)
    $past(!arm) |-> (!armed_o && state_o == 2'b01));
  p_idle_hold_r6: assert property (@(posedge clk) disable iff (rst)
    $past(!armed_q && arm_q && arm) |-> ($stable(state_o) && !armed_o));
endmodule

// File: tb/seq_trigger_sequencer_test.sv
`timescale 1ns/1ps
module seq_trigger_sequencer_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] page_sel = 2'b00;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data;
  logic       arm = 1'b0;
  logic [2:0] match = '0;
  logic [1:0] state_o;
  logic       armed_o;
  logic       final_o;

  int errors = 0;
  int checks = 0;
  int cycles = 0;

  always #2 clk = ~clk;

  seq_trigger_sequencer uut (
    .clk(clk), .rst(rst), .page_sel(page_sel), .wr_en(wr_en),
    .wr_data(wr_data), .rd_data(rd_data), .arm(arm), .match(match),
    .state_o(state_o), .armed_o(armed_o), .final_o(final_o)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 200000) begin
      errors = errors + 1;
      checks = checks + 1;
      $display("FAIL watchdog: actual=%0d cycles expected=<200000", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] pg, input logic [7:0] d);
    page_sel = pg; wr_en = 1'b1; wr_data = d;
    tick();
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] pg, output logic [7:0] d);
    page_sel = pg;
    tick();
    d = rd_data;
  endtask

  task automatic pulse(input logic [2:0] m);
    match = m;
    tick();
    match = '0;
  endtask

  task automatic arm_up();
    arm = 1'b0; tick();
    arm = 1'b1; tick();
  endtask

  // Expected route {hit, dest}, from the requirement tables
  function automatic logic [2:0] exp_route(input int st, input int code, input int ch);
    if (st == 1 || st == 3) begin
      if (code == 13) return (ch == 1) ? 3'b110 : 3'b100;
      return 3'b000;
    end
    if (code == 0 && ch == 0) return 3'b101;
    if (code == 0 && ch == 2) return 3'b111;
    if (code == 1 && ch == 1) return 3'b111;
    if (code == 2 && ch == 2) return 3'b111;
    if (code == 3 && ch == 0) return 3'b100;
    if (code == 3 && ch == 1) return 3'b111;
    if (code == 4 && ch == 1) return 3'b101;
    if (code == 4 && ch == 2) return 3'b111;
    return 3'b000;
  endfunction

  initial begin
    logic [7:0] d;
    int s1c, s2c, s3c, exp_st, got_final;
    logic [2:0] r;
    repeat (3) tick();
    rst = 1'b0;
    tick();
    // R1 reset state
    check("R1 state", state_o, 1);
    check("R1 armed", armed_o, 0);
    check("R1 final", final_o, 0);
    check("R1 rd_data", rd_data, 0);
    for (int p = 0; p < 3; p++) begin
      rd(p[1:0], d);
      check("R1 code zero", d, 0);
    end

    // R8 window, upper bits zero, page 11 empty
    wr(2'b01, 8'hA7);
    wr(2'b00, 8'h3C);
    wr(2'b11, 8'hFF);
    rd(2'b01, d); check("R8 page01 read", d, 8'h07);
    rd(2'b00, d); check("R8 page00 read", d, 8'h0C);
    rd(2'b10, d); check("R8 page10 read", d, 8'h00);
    rd(2'b11, d); check("R8 page11 read", d, 8'h00);

    // R9 writes locked while armed
    arm_up();
    check("R2 armed after rise", armed_o, 1);
    check("R2 state after arm", state_o, 1);
    wr(2'b01, 8'h05);
    arm = 1'b0; tick();
    check("R2 disarmed", armed_o, 0);
    rd(2'b01, d); check("R9 locked write", d, 8'h07);

    // R6 matches ignored while disarmed
    wr(2'b00, 8'h0D);
    pulse(3'b001);
    check("R6 disarmed match state", state_o, 1);
    check("R6 disarmed match final", final_o, 0);

    // Exhaustive sweep: state x code x match combination
    for (int st = 1; st <= 3; st++) begin
      for (int code = 0; code < 16; code++) begin
        for (int m = 1; m < 8; m++) begin
          arm = 1'b0; tick();
          s1c = (st == 1) ? code : 13;
          s2c = (st == 2) ? code : ((st == 3) ? 1 : 0);
          s3c = (st == 3) ? code : 0;
          wr(2'b00, 8'(s1c));
          wr(2'b01, 8'(s2c));
          wr(2'b10, 8'(s3c));
          arm = 1'b1; tick();
          if (st >= 2) pulse(3'b010);
          if (st == 3) pulse(3'b010);
          check("R2 reach state", state_o, st);
          // expected outcome (R5 priority)
          exp_st = st;
          got_final = 0;
          for (int ch = 2; ch >= 0; ch--) begin
            r = exp_route(st, code, ch);
            if (m[ch] && r[2]) exp_st = r[1:0];
          end
          for (int ch = 0; ch < 3; ch++) begin
            r = exp_route(st, code, ch);
            if (m[ch] && r[2] && r[1:0] == 2'b00) got_final = 1;
          end
          if (got_final) exp_st = 0;
          pulse(m[2:0]);
          if (st == 2)
            check("R4 R5 R6 state2 next", state_o, exp_st);
          else if (st == 1)
            check("R3 R5 R6 state1 next", state_o, exp_st);
          else
            check("R10 R5 state3 next", state_o, exp_st);
          check("R7 final pulse", final_o, got_final);
          if (got_final) begin
            check("R7 disarm", armed_o, 0);
            tick();
            check("R7 single pulse", final_o, 0);
            check("R7 hold final", state_o, 0);
          end
        end
      end
    end

    arm = 1'b0; tick();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule